// File: doc/BRIEF.md
# Preamble Regenerating Elasticity Buffer

This block moves a received nibble stream from a recovered receive clock onto the local transmit clock. It does not forward the received preamble. As soon as enough frame content is stored, it sends its own preamble at full length on the transmit side: fifteen nibbles of 5, then one nibble of D. Received nibbles are not kept until the start-of-frame delimiter (a D nibble) has been seen on the receive side. Every nibble after the delimiter is then written into a dual-clock FIFO. Each FIFO entry holds the nibble, its receive error bit, an overflow mark and an end-of-frame marker.

The transmit side starts the preamble when `DEPTH/2 - 16` entries are stored, so the FIFO holds about half its depth when the preamble ends. It also starts the preamble when the receive frame has already ended and at least one entry is stored. Once the D nibble has gone out, it reads one entry per cycle to the transmit nibble port. The two pointers cross the clock boundary in Gray code through two-flop synchronizers. With a depth of 64, a 1518-byte frame at a 200 ppm offset drifts by less than one nibble, which is well inside the half-depth margin. If the FIFO runs empty or drops a write, the transmit error output stays high until the frame ends. The collision input is accepted but has no effect on the preamble.

Top module: `prb_elastic_buf`

## Requirements
- R1: Each transmitted frame begins with exactly fifteen 4'h5 nibbles followed by one 4'hD nibble, on consecutive transmit cycles starting at the cycle `tx_en` rises.
- R2: Holding `col_in` high during the regenerated preamble neither shortens nor alters it.
- R3: Nibbles received before the first 4'hD nibble of a carrier event are not forwarded, and neither is that 4'hD nibble itself. A carrier event that contains no 4'hD nibble produces no transmit activity at all.
- R4: The received nibbles that follow the delimiter appear on `tx_d` in order, starting on the cycle right after the 4'hD preamble nibble, with no gap while the clocks are equal in frequency.
- R5: A nibble received with `rx_er` high is transmitted with `tx_er` high. The other nibbles of a healthy frame are transmitted with `tx_er` low, and the preamble is always transmitted with `tx_er` low.
- R6: A frame with less frame content than the prefill threshold is still forwarded in full once its receive carrier has ended.
- R7: If the FIFO runs empty during a frame, or a write is dropped because the FIFO is full, `tx_er` rises and stays high until `tx_en` falls. While the FIFO is empty, `tx_en` stays high.
- R8: `tx_en` stays high without a break for the whole frame and falls exactly one cycle after the last nibble, so a healthy frame with N payload nibbles holds `tx_en` for N+16 cycles.
- R9: While `rst_n` is low, `tx_en`, `tx_er` and `tx_d` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive clock |
| tx_clk | input | 1 | Local transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rx_dv | input | 1 | Receive carrier / data valid (rx_clk) |
| rx_d | input | 4 | Receive nibble (rx_clk) |
| rx_er | input | 1 | Receive error for the current nibble (rx_clk) |
| col_in | input | 1 | Collision indication; has no effect on the preamble |
| tx_en | output | 1 | Transmit enable (tx_clk) |
| tx_d | output | 4 | Transmit nibble (tx_clk) |
| tx_er | output | 1 | Transmit error (tx_clk) |

## Verification
The moment `tx_en` first rises depends on the phase between the clocks and on the two synchronizer stages. The bench therefore times every result from that rise rather than from the stimulus. The preamble nibbles are due at rise offsets 0 to 15, the first payload nibble at offset 16, and `tx_en` must be low at offset N+16. The bench captures outputs on the falling edge of `tx_clk`, half a period after the registering edge, and compares the captured run position by position against values it rebuilds from the stimulus. Where a result has no fixed offset (error stickiness under underflow or overflow, and the absence of any output for a frame without a delimiter), the bench checks for the property over the whole captured run or over a bounded wait.

// File: rtl/prb_pkg.sv
`timescale 1ns/1ps
package prb_pkg;
  localparam logic [3:0] NIB_PRE = 4'h5;
  localparam logic [3:0] NIB_SFD = 4'hD;
  localparam int PRE_NIBBLES = 16;

  typedef struct packed {
    logic       eof;
    logic       ovf;
    logic       er;
    logic [3:0] d;
  } fifo_ent_t;

  typedef enum logic [1:0] {W_HUNT, W_COPY, W_EOF} wr_st_t;
  typedef enum logic [1:0] {T_IDLE, T_PRE, T_DATA} rd_st_t;

  function automatic logic [15:0] bin2gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] gray2bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Occupancy from two free-running pointers (modulo the caller's width).
  function automatic logic [15:0] ptr_fill(input logic [15:0] wp, input logic [15:0] rp);
    return wp - rp;
  endfunction

  // Level at which the preamble is launched so that half depth is stored when it ends.
  function automatic int start_level(input int depth);
    return (depth / 2 > PRE_NIBBLES) ? depth / 2 - PRE_NIBBLES : 1;
  endfunction
endpackage

// File: rtl/prb_sync.sv
`timescale 1ns/1ps
module prb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/prb_ram.sv
`timescale 1ns/1ps
module prb_ram
  import prb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  fifo_ent_t     wdata,
  input  logic [AW-1:0] raddr,
  output fifo_ent_t     rdata
);
  localparam int DEPTH = 1 << AW;

  fifo_ent_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/prb_wr_ctl.sv
`timescale 1ns/1ps
module prb_wr_ctl
  import prb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          rx_clk,
  input  logic          rst_n,
  input  logic          rx_dv,
  input  logic [3:0]    rx_d,
  input  logic          rx_er,
  input  logic [AW:0]   rd_gray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output fifo_ent_t     wdata,
  output logic [AW:0]   wr_gray,
  output logic          busy
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  wr_st_t      st, st_nx;
  logic [AW:0] wr_bin, wr_bin_nx, rd_bin_s, wr_fill;
  logic        ovf_q, full, drop, sfd_seen;

  assign rd_bin_s = PW'(gray2bin(16'(rd_gray_s)));
  assign wr_fill  = PW'(ptr_fill(16'(wr_bin), 16'(rd_bin_s)));
  assign full     = (wr_fill == PW'(DEPTH));
  assign sfd_seen = rx_dv && (rx_d == NIB_SFD);

  always_comb begin
    st_nx       = st;
    we          = 1'b0;
    drop        = 1'b0;
    wdata.eof   = 1'b1;
    wdata.ovf   = ovf_q;
    wdata.er    = 1'b0;
    wdata.d     = 4'h0;
    case (st)
      W_HUNT: begin
        if (sfd_seen) st_nx = W_COPY;
      end
      W_COPY: begin
        if (rx_dv) begin
          wdata.eof = 1'b0;
          wdata.er  = rx_er;
          wdata.d   = rx_d;
          we        = !full;
          drop      = full;
        end else begin
          we    = !full;
          st_nx = full ? W_EOF : W_HUNT;
        end
      end
      W_EOF: begin
        we = !full;
        if (!full) st_nx = W_HUNT;
      end
      default: st_nx = W_HUNT;
    endcase
  end

  assign wr_bin_nx = wr_bin + PW'(we);
  assign waddr     = wr_bin[AW-1:0];

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_HUNT;
      wr_bin  <= '0;
      wr_gray <= '0;
      ovf_q   <= 1'b0;
      busy    <= 1'b0;
    end else begin
      st      <= st_nx;
      wr_bin  <= wr_bin_nx;
      wr_gray <= PW'(bin2gray(16'(wr_bin_nx)));
      busy    <= (st_nx != W_HUNT);
      if (st_nx == W_HUNT) ovf_q <= 1'b0;
      else if (drop)       ovf_q <= 1'b1;
    end
  end

  AST_HUNT_NO_STORE: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (st == W_HUNT && !sfd_seen) |=> $stable(wr_bin)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge rx_clk) disable iff (!rst_n)
    wr_fill <= PW'(DEPTH)); // R7
endmodule

// File: rtl/prb_rd_ctl.sv
`timescale 1ns/1ps
module prb_rd_ctl
  import prb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          tx_clk,
  input  logic          rst_n,
  input  logic [AW:0]   wr_gray_s,
  input  logic          busy_s,
  input  logic          col_in,
  input  fifo_ent_t     rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rd_gray,
  output logic          tx_en,
  output logic [3:0]    tx_d,
  output logic          tx_er
);
  localparam int PW        = AW + 1;
  localparam int DEPTH     = 1 << AW;
  localparam int START_LVL = start_level(DEPTH);
  localparam int CW        = $clog2(PRE_NIBBLES);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE_NIBBLES - 1);

  rd_st_t      st;
  logic [CW-1:0] pre_cnt;
  logic [AW:0] rd_bin, rd_bin_nx, wr_bin_s, fill;
  logic        have, start_ok, pop, eof_pop, uflow, sticky;

  assign wr_bin_s = PW'(gray2bin(16'(wr_gray_s)));
  assign fill     = PW'(ptr_fill(16'(wr_bin_s), 16'(rd_bin)));
  assign have     = (fill != '0);
  assign start_ok = (fill >= PW'(START_LVL)) || (have && !busy_s);
  assign pop      = (st == T_DATA) && have;
  assign eof_pop  = pop && rdata.eof;
  assign uflow    = (st == T_DATA) && !have;
  assign rd_bin_nx = rd_bin + PW'(pop);
  assign raddr    = rd_bin[AW-1:0];

  always_ff @(posedge tx_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else begin
      rd_bin  <= rd_bin_nx;
      rd_gray <= PW'(bin2gray(16'(rd_bin_nx)));
    end
  end

  always_ff @(posedge tx_clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      pre_cnt <= '0;
      sticky  <= 1'b0;
      tx_en   <= 1'b0;
      tx_d    <= 4'h0;
      tx_er   <= 1'b0;
    end else begin
      case (st)
        T_IDLE: begin
          tx_en  <= 1'b0;
          tx_d   <= 4'h0;
          tx_er  <= 1'b0;
          sticky <= 1'b0;
          pre_cnt <= '0;
          if (start_ok) st <= T_PRE;
        end
        T_PRE: begin
          tx_en   <= 1'b1;
          tx_er   <= 1'b0;
          tx_d    <= (pre_cnt == PRE_LAST) ? NIB_SFD : NIB_PRE;
          pre_cnt <= pre_cnt + 1'b1;
          if (pre_cnt == PRE_LAST) st <= T_DATA;
        end
        T_DATA: begin
          if (uflow) begin
            tx_en  <= 1'b1;
            tx_d   <= 4'h0;
            tx_er  <= 1'b1;
            sticky <= 1'b1;
          end else if (rdata.eof) begin
            tx_en  <= 1'b0;
            tx_d   <= 4'h0;
            tx_er  <= 1'b0;
            sticky <= 1'b0;
            st     <= T_IDLE;
          end else begin
            tx_en  <= 1'b1;
            tx_d   <= rdata.d;
            tx_er  <= rdata.er | rdata.ovf | sticky;
            sticky <= sticky | rdata.ovf;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  AST_PRE_SHAPE: assert property (@(posedge tx_clk) disable iff (!rst_n)
    (st == T_PRE) |=> (tx_en && !tx_er && (tx_d == NIB_PRE || tx_d == NIB_SFD))); // R1
  AST_COL_NO_CUT: assert property (@(posedge tx_clk) disable iff (!rst_n)
    (st == T_PRE && col_in) |=> tx_en); // R2
  AST_STICKY_ERR: assert property (@(posedge tx_clk) disable iff (!rst_n)
    (sticky && st == T_DATA && !eof_pop) |=> tx_er); // R7
  AST_EN_DROP: assert property (@(posedge tx_clk) disable iff (!rst_n)
    eof_pop |=> !tx_en); // R8
  AST_NO_UNDERREAD: assert property (@(posedge tx_clk) disable iff (!rst_n)
    fill <= PW'(DEPTH)); // R7
endmodule

// File: rtl/prb_elastic_buf.sv
`timescale 1ns/1ps
module prb_elastic_buf
  import prb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       rx_clk,
  input  logic       tx_clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic [3:0] rx_d,
  input  logic       rx_er,
  input  logic       col_in,
  output logic       tx_en,
  output logic [3:0] tx_d,
  output logic       tx_er
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  fifo_ent_t     wdata, rdata;
  logic [AW:0]   wr_gray, rd_gray, rd_gray_s, wr_gray_s;
  logic          busy, busy_s;
  logic [PW:0]   to_tx_q;

  prb_wr_ctl #(.AW(AW)) u_wr (
    .rx_clk(rx_clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_d(rx_d), .rx_er(rx_er),
    .rd_gray_s(rd_gray_s), .we(we), .waddr(waddr), .wdata(wdata),
    .wr_gray(wr_gray), .busy(busy)
  );

  prb_ram #(.AW(AW)) u_ram (
    .wclk(rx_clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );

  prb_sync #(.W(PW + 1)) u_sync_w2r (
    .clk(tx_clk), .rst_n(rst_n), .d({busy, wr_gray}), .q(to_tx_q)
  );
  assign busy_s    = to_tx_q[PW];
  assign wr_gray_s = to_tx_q[PW-1:0];

  prb_sync #(.W(PW)) u_sync_r2w (
    .clk(rx_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  prb_rd_ctl #(.AW(AW)) u_rd (
    .tx_clk(tx_clk), .rst_n(rst_n), .wr_gray_s(wr_gray_s), .busy_s(busy_s),
    .col_in(col_in), .rdata(rdata), .raddr(raddr), .rd_gray(rd_gray),
    .tx_en(tx_en), .tx_d(tx_d), .tx_er(tx_er)
  );
endmodule

// File: tb/tb_prb_elastic_buf.sv
`timescale 1ns/1ps
module tb_prb_elastic_buf;
  logic tx_clk = 1'b0, rx_clk = 1'b0, rst_n = 1'b0;
  logic rx_dv = 1'b0, rx_er = 1'b0, col_in = 1'b0;
  logic [3:0] rx_d = 4'h0;
  logic tx_en, tx_er;
  logic [3:0] tx_d;
  int rx_half = 5;

  int total = 0, bad = 0, cyc = 0;
  logic [3:0] cap_d [1024];
  bit cap_e [1024];
  int ncap = 0, rises = 0;
  bit prev_en = 1'b0, clr_req = 1'b0;

  prb_elastic_buf #(.DEPTH(64)) dut (
    .rx_clk(rx_clk), .tx_clk(tx_clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_d(rx_d),
    .rx_er(rx_er), .col_in(col_in), .tx_en(tx_en), .tx_d(tx_d), .tx_er(tx_er)
  );

  always #5 tx_clk = ~tx_clk;
  initial begin
    #2;
    forever #(rx_half) rx_clk = ~rx_clk;
  end

  // rows: rx preamble length, payload nibbles, seed, error position (-1 none)
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{15, 40, 1, -1},
    '{7, 64, 2, 10},
    '{15, 100, 3, 0},
    '{3, 5, 4, 4},
    '{15, 33, 5, -1},
    '{1, 1, 6, -1}
  };

  function automatic logic [3:0] pay(input int seed, input int i);
    return 4'((seed * 5 + i * 3 + (i >> 2)) & 15);
  endfunction

  always @(negedge tx_clk) begin
    if (clr_req) begin
      ncap = 0;
      rises = 0;
    end else if (tx_en) begin
      if (!prev_en) rises++;
      if (ncap < 1024) begin
        cap_d[ncap] = tx_d;
        cap_e[ncap] = tx_er;
        ncap++;
      end
    end
    prev_en = tx_en;
  end

  always @(posedge tx_clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_cap();
    @(posedge tx_clk); #1 clr_req = 1'b1;
    @(posedge tx_clk); #1 clr_req = 1'b0;
  endtask

  task automatic send_frame(input int npre, input int plen, input int seed,
                            input int erpos, input bit with_sfd);
    for (int i = 0; i < npre; i++) begin
      @(negedge rx_clk); rx_dv = 1'b1; rx_d = 4'h5; rx_er = 1'b0;
    end
    if (with_sfd) begin
      @(negedge rx_clk); rx_dv = 1'b1; rx_d = 4'hD;
    end
    for (int i = 0; i < plen; i++) begin
      @(negedge rx_clk); rx_d = pay(seed, i); rx_er = (i == erpos);
    end
    @(negedge rx_clk); rx_dv = 1'b0; rx_d = 4'h0; rx_er = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge tx_clk);
      if (ncap > 0 && !tx_en) break;
    end
    repeat (4) @(negedge tx_clk);
  endtask

  task automatic check_frame(input int plen, input int seed, input int erpos, input string rq);
    int pre_bad = 0, dat_bad = 0, er_bad = 0;
    chk(ncap == plen + 16, (plen < 16) ? "R6/R8 length" : "R8 length", ncap, plen + 16);
    chk(rises == 1, "R8 contiguous enable", rises, 1);
    for (int i = 0; i < 15; i++) if (cap_d[i] != 4'h5 || cap_e[i]) pre_bad++;
    chk(pre_bad == 0, {rq, " R1 preamble fives"}, pre_bad, 0);
    chk(cap_d[15] == 4'hD, "R1 delimiter nibble", int'(cap_d[15]), 13);
    for (int i = 0; i < plen; i++) begin
      if (cap_d[16 + i] != pay(seed, i)) dat_bad++;
      if (cap_e[16 + i] != (i == erpos)) er_bad++;
    end
    chk(dat_bad == 0, "R4/R3 payload order", dat_bad, 0);
    chk(er_bad == 0, "R5 error marking", er_bad, 0);
  endtask

  task automatic check_sticky(input string rq);
    int first = -1, holes = 0;
    for (int i = 0; i < ncap; i++) begin
      if (cap_e[i] && first < 0) first = i;
      if (first >= 0 && !cap_e[i]) holes++;
    end
    chk(first >= 16, {rq, " error raised after preamble"}, first, 16);
    chk(holes == 0, {rq, " error held to frame end"}, holes, 0);
    chk(rises == 1, {rq, " enable held"}, rises, 1);
  endtask

  initial begin
    repeat (4) @(negedge tx_clk);
    // R9: reset state
    chk(tx_en == 1'b0, "R9 tx_en in reset", int'(tx_en), 0);
    chk(tx_er == 1'b0, "R9 tx_er in reset", int'(tx_er), 0);
    chk(tx_d == 4'h0, "R9 tx_d in reset", int'(tx_d), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge tx_clk);

    for (int v = 0; v < NV; v++) begin
      clear_cap();
      send_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b1);
      wait_done();
      check_frame(VEC[v][1], VEC[v][2], VEC[v][3], "R3");
    end

    // R3: carrier without delimiter produces nothing
    clear_cap();
    send_frame(20, 0, 0, -1, 1'b0);
    repeat (200) @(negedge tx_clk);
    chk(ncap == 0, "R3 no delimiter, no output", ncap, 0);

    // R2: collision held across the whole frame
    clear_cap();
    @(negedge rx_clk); col_in = 1'b1;
    send_frame(15, 40, 7, -1, 1'b1);
    wait_done();
    col_in = 1'b0;
    check_frame(40, 7, -1, "R2");

    // R7: underflow with a slow receive clock
    rx_half = 8;
    repeat (10) @(negedge tx_clk);
    clear_cap();
    send_frame(15, 120, 8, -1, 1'b1);
    wait_done();
    check_sticky("R7 underflow");

    // R7: overflow with a fast receive clock
    rx_half = 3;
    repeat (10) @(negedge tx_clk);
    clear_cap();
    send_frame(15, 250, 9, -1, 1'b1);
    wait_done();
    check_sticky("R7 overflow");

    // R4: equal clocks again, back-to-back frame still clean
    rx_half = 5;
    repeat (10) @(negedge tx_clk);
    clear_cap();
    send_frame(15, 48, 10, 47, 1'b1);
    wait_done();
    check_frame(48, 10, 47, "R4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule